// File: doc/BRIEF.md
# Address-Routed Egress Selector for a Packet Switch

This block picks the destination of an address-routed request inside a small packet switch that has one upstream port (port 0) and `N_PORTS` downstream ports (ports 1 to `N_PORTS`). Each request arrives as an already decoded header: whether it targets IO or memory space, whether it carries a 64-bit address, the address itself, and the number of the port it came in on. Configuration arrives on plain pins. These pins give two address ranges owned by the switch itself, each tagged as IO or memory, and three windows for every downstream port: an IO window, a 32-bit non-prefetchable memory window and a 64-bit prefetchable memory window.

The ranges are checked in a fixed order. The switch's own ranges come first, and a hit means the switch keeps the packet. Next come the downstream windows that belong to the request's address space. If no window matches, the result depends on the ingress side. A packet from a downstream port goes upstream. A packet from the upstream port is reported as an unsupported request.

Requests enter through a valid/ready handshake. The block registers one decision at a time and holds it until the consumer takes it. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, `in_ready` stays low and the decision pins do not change.

Top module: `addr_port_select`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A range or window matches when lower bound ≤ address ≤ upper bound, with both bounds inclusive. If the lower bound is greater than the upper bound, the range is disabled and never matches.
- R3: A hit in either of the switch's own ranges yields `out_kind`=0 (consume), and this takes priority over any downstream window. An own range only applies to requests whose space (`own_is_io` bit: 1=IO, 0=memory) equals the request's space.
- R4: A memory request is compared against each port's non-prefetchable and prefetchable windows. An IO request is compared only against each port's IO window.
- R5: When `in_addr64`=0, and for every IO request, only `in_addr[31:0]` is used, zero-extended to 64 bits. A memory address with non-zero upper 32 bits never matches a 32-bit non-prefetchable window.
- R6: When several downstream windows match, the result is `out_kind`=1 with `out_port` set to the lowest-numbered matching port.
- R7: A window hit on the port the request arrived on is ignored, so a request is never sent back out of its ingress port.
- R8: A request from port 0 that misses every range yields `out_kind`=3 (unsupported request) with `out_port`=0.
- R9: A request from a downstream port that misses every range yields `out_kind`=2 (upstream) with `out_port`=0.
- R10: A request accepted on a rising edge (`in_valid` and `in_ready` both high) produces its decision with `out_valid`=1 right after that edge. `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, the decision is held unchanged.
- R11: `out_kind` is encoded as 0=consume, 1=downstream, 2=upstream, 3=unsupported. For consume it reports `out_port`=0, and for downstream it reports a port in 1..`N_PORTS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_is_io | input | 1 | 1 = IO request, 0 = memory request |
| in_addr64 | input | 1 | 1 = memory request carries a 64-bit address |
| in_addr | input | 64 | Request address |
| in_src | input | PW | Ingress port number (0 = upstream) |
| own_lo | input | 128 | Lower bounds of the two own ranges, 64 bits each |
| own_hi | input | 128 | Upper bounds of the two own ranges |
| own_is_io | input | 2 | Space of each own range (1 = IO) |
| io_lo | input | 32·N | Per-port IO window lower bounds |
| io_hi | input | 32·N | Per-port IO window upper bounds |
| np_lo | input | 32·N | Per-port non-prefetchable lower bounds |
| np_hi | input | 32·N | Per-port non-prefetchable upper bounds |
| pf_lo | input | 64·N | Per-port prefetchable lower bounds |
| pf_hi | input | 64·N | Per-port prefetchable upper bounds |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes the decision |
| out_kind | output | 2 | Decision kind (see R11) |
| out_port | output | PW | Egress port number |

## Verification
The assertions assume that `in_src` never exceeds `N_PORTS`, and one of them checks this at the input. They also assume the configuration pins do not change while a request is being accepted. The stimulus keeps to both assumptions. Random ingress numbers are drawn only from 0 to `N_PORTS`, and configuration is only rewritten between requests while the block is idle. Bounds and addresses come from a narrow numeric range, with some lower bounds placed above their upper bounds, so that hits, overlaps, disabled windows and misses all occur often.

// File: rtl/sw_route_pkg.sv
package sw_route_pkg;
  typedef enum logic [1:0] {
    RT_LOCAL  = 2'd0,
    RT_DOWN   = 2'd1,
    RT_UP     = 2'd2,
    RT_UNSUP  = 2'd3
  } route_kind_e;

  localparam int unsigned ADDR_W = 64;
  localparam int unsigned IO_W   = 32;
  localparam int unsigned NP_W   = 32;
  localparam int unsigned OWN_N  = 2;
endpackage

// File: rtl/win_match.sv
module win_match #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] addr,
  output logic         hit
);
  logic enabled;
  assign enabled = (lo <= hi);
  assign hit     = enabled && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/port_window_bank.sv
module port_window_bank
  import sw_route_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned PW = $clog2(N_PORTS + 1)
) (
  input  logic                     is_io,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [PW-1:0]            src,
  input  logic [N_PORTS*IO_W-1:0]  io_lo,
  input  logic [N_PORTS*IO_W-1:0]  io_hi,
  input  logic [N_PORTS*NP_W-1:0]  np_lo,
  input  logic [N_PORTS*NP_W-1:0]  np_hi,
  input  logic [N_PORTS*ADDR_W-1:0] pf_lo,
  input  logic [N_PORTS*ADDR_W-1:0] pf_hi,
  output logic [N_PORTS-1:0]       hit
);
  logic upper_zero;
  assign upper_zero = (addr[ADDR_W-1:NP_W] == '0);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic io_hit, np_hit, pf_hit, space_hit, is_ingress;

    win_match #(.W(IO_W)) u_io (
      .lo(io_lo[p*IO_W +: IO_W]), .hi(io_hi[p*IO_W +: IO_W]),
      .addr(addr[IO_W-1:0]), .hit(io_hit));

    win_match #(.W(NP_W)) u_np (
      .lo(np_lo[p*NP_W +: NP_W]), .hi(np_hi[p*NP_W +: NP_W]),
      .addr(addr[NP_W-1:0]), .hit(np_hit));

    win_match #(.W(ADDR_W)) u_pf (
      .lo(pf_lo[p*ADDR_W +: ADDR_W]), .hi(pf_hi[p*ADDR_W +: ADDR_W]),
      .addr(addr), .hit(pf_hit));

    assign space_hit  = is_io ? io_hit : ((np_hit && upper_zero) || pf_hit);
    assign is_ingress = (src == PW'(p + 1));
    assign hit[p]     = space_hit && !is_ingress;
  end
endmodule

// File: rtl/lowest_port_pick.sv
module lowest_port_pick #(
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned PW = $clog2(N_PORTS + 1)
) (
  input  logic [N_PORTS-1:0] req,
  output logic               any,
  output logic [N_PORTS-1:0] grant,
  output logic [PW-1:0]      port
);
  always_comb begin
    any   = |req;
    grant = '0;
    port  = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        port     = PW'(i + 1);
      end
    end
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R6
    AST_GRANT_IN_REQ: assert ((grant & ~req) == '0); // R6
  end
endmodule

// File: rtl/addr_port_select.sv
module addr_port_select
  import sw_route_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned PW = $clog2(N_PORTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_is_io,
  input  logic                      in_addr64,
  input  logic [ADDR_W-1:0]         in_addr,
  input  logic [PW-1:0]             in_src,
  input  logic [OWN_N*ADDR_W-1:0]   own_lo,
  input  logic [OWN_N*ADDR_W-1:0]   own_hi,
  input  logic [OWN_N-1:0]          own_is_io,
  input  logic [N_PORTS*IO_W-1:0]   io_lo,
  input  logic [N_PORTS*IO_W-1:0]   io_hi,
  input  logic [N_PORTS*NP_W-1:0]   np_lo,
  input  logic [N_PORTS*NP_W-1:0]   np_hi,
  input  logic [N_PORTS*ADDR_W-1:0] pf_lo,
  input  logic [N_PORTS*ADDR_W-1:0] pf_hi,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [1:0]                out_kind,
  output logic [PW-1:0]             out_port
);
  localparam logic [PW-1:0] LAST_PORT = PW'(N_PORTS);

  // effective address: short forms are zero-extended
  logic [ADDR_W-1:0] eff_addr;
  assign eff_addr = (in_is_io || !in_addr64) ? {{(ADDR_W-IO_W){1'b0}}, in_addr[IO_W-1:0]} : in_addr;

  // own ranges
  logic [OWN_N-1:0] own_hit;
  for (genvar b = 0; b < OWN_N; b++) begin : g_own
    logic range_hit;
    win_match #(.W(ADDR_W)) u_own (
      .lo(own_lo[b*ADDR_W +: ADDR_W]), .hi(own_hi[b*ADDR_W +: ADDR_W]),
      .addr(eff_addr), .hit(range_hit));
    assign own_hit[b] = range_hit && (own_is_io[b] == in_is_io);
  end

  // downstream windows
  logic [N_PORTS-1:0] dn_hit;
  port_window_bank #(.N_PORTS(N_PORTS)) u_bank (
    .is_io(in_is_io), .addr(eff_addr), .src(in_src),
    .io_lo(io_lo), .io_hi(io_hi), .np_lo(np_lo), .np_hi(np_hi),
    .pf_lo(pf_lo), .pf_hi(pf_hi), .hit(dn_hit));

  logic               dn_any;
  logic [N_PORTS-1:0] dn_grant;
  logic [PW-1:0]      dn_port;
  lowest_port_pick #(.N_PORTS(N_PORTS)) u_pick (
    .req(dn_hit), .any(dn_any), .grant(dn_grant), .port(dn_port));

  // priority resolution
  route_kind_e  nxt_kind;
  logic [PW-1:0] nxt_port;
  always_comb begin
    nxt_port = '0;
    if (|own_hit) begin
      nxt_kind = RT_LOCAL;
    end else if (dn_any) begin
      nxt_kind = RT_DOWN;
      nxt_port = dn_port;
    end else if (in_src == '0) begin
      nxt_kind = RT_UNSUP;
    end else begin
      nxt_kind = RT_UP;
    end
  end

  // output register with valid/ready
  logic take;
  logic [PW-1:0] src_q;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= RT_LOCAL;
      out_port  <= '0;
      src_q     <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_kind  <= nxt_kind;
      out_port  <= nxt_port;
      src_q     <= in_src;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> in_src <= LAST_PORT); // R11
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) take |=> out_valid); // R10
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_port)); // R10
  AST_NO_REFLECT: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_kind == RT_DOWN |-> out_port != src_q); // R7
  AST_DOWN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_kind == RT_DOWN |-> out_port != '0 && out_port <= LAST_PORT); // R11
  AST_UNSUP_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_kind == RT_UNSUP |-> src_q == '0 && out_port == '0); // R8
  AST_UP_SECONDARY: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_kind == RT_UP |-> src_q != '0 && out_port == '0); // R9
endmodule

// File: tb/test_addr_port_select.sv
`timescale 1ns/1ps
module test_addr_port_select;
  localparam int N = 4;
  localparam int PW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic in_valid = 1'b0, in_is_io = 1'b0, in_addr64 = 1'b0, out_ready = 1'b1;
  logic [63:0] in_addr = '0;
  logic [PW-1:0] in_src = '0;
  logic in_ready, out_valid;
  logic [1:0] out_kind;
  logic [PW-1:0] out_port;

  logic [63:0] ob_lo [2], ob_hi [2];
  logic        ob_io [2];
  logic [31:0] iol [N], ioh [N], npl [N], nph [N];
  logic [63:0] pfl [N], pfh [N];

  logic [127:0] own_lo_f, own_hi_f;
  logic [1:0]   own_io_f;
  logic [N*32-1:0] io_lo_f, io_hi_f, np_lo_f, np_hi_f;
  logic [N*64-1:0] pf_lo_f, pf_hi_f;

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      own_lo_f[b*64 +: 64] = ob_lo[b];
      own_hi_f[b*64 +: 64] = ob_hi[b];
      own_io_f[b] = ob_io[b];
    end
    for (int p = 0; p < N; p++) begin
      io_lo_f[p*32 +: 32] = iol[p]; io_hi_f[p*32 +: 32] = ioh[p];
      np_lo_f[p*32 +: 32] = npl[p]; np_hi_f[p*32 +: 32] = nph[p];
      pf_lo_f[p*64 +: 64] = pfl[p]; pf_hi_f[p*64 +: 64] = pfh[p];
    end
  end

  addr_port_select #(.N_PORTS(N)) i_addr_port_select (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_io(in_is_io), .in_addr64(in_addr64), .in_addr(in_addr), .in_src(in_src),
    .own_lo(own_lo_f), .own_hi(own_hi_f), .own_is_io(own_io_f),
    .io_lo(io_lo_f), .io_hi(io_hi_f), .np_lo(np_lo_f), .np_hi(np_hi_f),
    .pf_lo(pf_lo_f), .pf_hi(pf_hi_f),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_port(out_port));

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic bit inr(logic [63:0] lo, logic [63:0] hi, logic [63:0] a);
    return (lo <= hi) && (a >= lo) && (a <= hi);
  endfunction

  // expected {kind, port} from the requirements
  function automatic logic [PW+1:0] ref_route(bit io, bit a64, logic [63:0] a, int src);
    logic [63:0] e;
    e = (io || !a64) ? {32'h0, a[31:0]} : a;
    for (int b = 0; b < 2; b++)
      if (ob_io[b] == io && inr(ob_lo[b], ob_hi[b], e)) return {2'd0, PW'(0)};   // R3
    for (int p = 0; p < N; p++) begin
      bit h;
      if (p + 1 == src) continue;                                                  // R7
      if (io) h = inr({32'h0, iol[p]}, {32'h0, ioh[p]}, {32'h0, e[31:0]});
      else    h = (e[63:32] == 0 && inr({32'h0, npl[p]}, {32'h0, nph[p]}, e)) || inr(pfl[p], pfh[p], e);
      if (h) return {2'd1, PW'(p + 1)};                                            // R6
    end
    if (src == 0) return {2'd3, PW'(0)};                                           // R8
    return {2'd2, PW'(0)};                                                         // R9
  endfunction

  task automatic chk(string req, logic [PW+1:0] act, logic [PW+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual kind=%0d port=%0d expected kind=%0d port=%0d", req,
               act[PW+1:PW], act[PW-1:0], exp[PW+1:PW], exp[PW-1:0]);
    end
  endtask

  task automatic chk1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one request with out_ready high; result checked one edge later
  task automatic send(string req, bit io, bit a64, logic [63:0] a, int src);
    logic [PW+1:0] exp;
    exp = ref_route(io, a64, a, src);
    @(negedge clk);
    in_valid = 1; in_is_io = io; in_addr64 = a64; in_addr = a; in_src = PW'(src);
    @(negedge clk);
    in_valid = 0;
    chk1({req, " valid"}, out_valid, 1'b1);
    chk(req, {out_kind, out_port}, exp);
  endtask

  task automatic set_directed();
    ob_lo[0] = 64'h1000_0000; ob_hi[0] = 64'h1000_FFFF; ob_io[0] = 0;
    ob_lo[1] = 64'h2000;      ob_hi[1] = 64'h20FF;      ob_io[1] = 1;
    for (int p = 0; p < N; p++) begin
      iol[p] = 32'h5000; ioh[p] = 32'h4000;
      npl[p] = 32'h9; nph[p] = 32'h1;
      pfl[p] = 64'h9; pfh[p] = 64'h1;
    end
    iol[0] = 32'h3000; ioh[0] = 32'h3FFF;
    npl[0] = 32'h4000_0000; nph[0] = 32'h4FFF_FFFF;
    pfl[0] = 64'h1_0000_0000; pfh[0] = 64'h1_FFFF_FFFF;
    npl[1] = 32'h4800_0000; nph[1] = 32'h5FFF_FFFF;
    iol[2] = 32'h6000; ioh[2] = 32'h6FFF;
    npl[2] = 32'h1000_8000; nph[2] = 32'h1000_8FFF;
    pfl[2] = 64'h2_0000_0000; pfh[2] = 64'h2_0000_0FFF;
    iol[3] = 32'h3000; ioh[3] = 32'h3FFF;
  endtask

  task automatic rnd_bound(output logic [63:0] lo, output logic [63:0] hi, input bit wide);
    logic [63:0] up;
    up = wide ? {31'h0, 1'($urandom % 2), 32'h0} : 64'h0;
    lo = up | 64'($urandom % 256);
    hi = lo + 64'($urandom % 64) - 64'd6;   // some windows end up disabled
  endtask

  task automatic set_random();
    logic [63:0] l, h;
    for (int b = 0; b < 2; b++) begin
      rnd_bound(l, h, 1); ob_lo[b] = l; ob_hi[b] = h; ob_io[b] = 1'($urandom % 2);
    end
    for (int p = 0; p < N; p++) begin
      rnd_bound(l, h, 0); iol[p] = l[31:0]; ioh[p] = h[31:0];
      rnd_bound(l, h, 0); npl[p] = l[31:0]; nph[p] = h[31:0];
      rnd_bound(l, h, 1); pfl[p] = l; pfh[p] = h;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PW+1:0] held;
    void'($urandom(32'd1234));
    set_directed();
    repeat (3) @(negedge clk);
    chk1("R1 out_valid after reset", out_valid, 1'b0);
    chk1("R1 in_ready after reset", in_ready, 1'b1);
    rst_n = 1;
    @(negedge clk);
    chk1("R1 idle after release", out_valid, 1'b0);

    send("R3 own mem range lower bound", 0, 0, 64'h1000_0000, 0);
    send("R3 own range beats port window", 0, 0, 64'h1000_8004, 0);
    send("R3 mem range ignores IO request / R8", 1, 0, 64'h1000_0000, 0);
    send("R2 R3 own IO range upper bound", 1, 0, 64'h20FF, 2);
    send("R6 lowest port among overlaps", 0, 0, 64'h4800_0000, 0);
    send("R7 ingress port skipped", 0, 0, 64'h4800_0000, 1);
    send("R7 R2 IO limit, ingress skipped", 1, 0, 64'h3FFF, 1);
    send("R2 IO limit inclusive", 1, 0, 64'h3FFF, 0);
    send("R2 disabled window / R8", 1, 0, 64'h5000, 0);
    send("R4 prefetchable 64-bit window", 0, 1, 64'h1_0000_0000, 3);
    send("R5 short address zero-extended", 0, 0, 64'hFFFF_FFFF_4000_0000, 2);
    send("R5 R9 high address misses 32-bit window", 0, 1, 64'h3_4000_0000, 2);
    send("R5 IO uses low 32 bits", 1, 1, 64'hFFFF_0000_0000_6000, 0);
    send("R4 IO request ignores memory windows / R9", 1, 0, 64'h4000_0000, 4);

    // R10 back-pressure
    @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_is_io = 1; in_addr64 = 0; in_addr = 64'h6000; in_src = 0;
    @(negedge clk);
    held = {out_kind, out_port};
    chk("R10 result after accept", held, {2'd1, PW'(3)});
    chk1("R10 in_ready low when stalled", in_ready, 1'b0);
    in_is_io = 0; in_addr = 64'h4000_0000; in_src = 2;
    repeat (2) @(negedge clk);
    chk1("R10 valid held", out_valid, 1'b1);
    chk("R10 decision held", {out_kind, out_port}, held);
    out_ready = 1;
    #0;
    chk1("R10 in_ready follows out_ready", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 0;
    chk("R10 next request taken", {out_kind, out_port}, {2'd1, PW'(1)});
    @(negedge clk);
    chk1("R10 drained", out_valid, 1'b0);

    // constrained random
    for (int cfg = 0; cfg < 20; cfg++) begin
      set_random();
      for (int k = 0; k < 20; k++) begin
        bit io, a64;
        logic [63:0] a;
        io = 1'($urandom % 3 == 0);
        a64 = 1'($urandom % 2);
        a = {(($urandom % 3 == 0) ? 32'($urandom) : 32'(($urandom % 2))), 32'($urandom % 320)};
        send("R2-random R3 R4 R5 R6 R7 R8 R9", io, a64, a, int'($urandom % (N + 1)));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule